// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register storage of a 32-bit processor core. It gives sixteen architectural registers, numbered 0 to 15. Indices 8 to 15 always reach one shared set of eight registers. Indices 0 to 7 reach one of two physical copies, called bank 0 and bank 1. The copy in use depends on two state bits that the block keeps: a privileged-mode bit and a bank-select bit. A user-mode core sees only bank 0. Privileged code chooses its bank with the bank-select bit.

Two combinational read ports and one write port serve the normal datapath. A separate alternate port always reaches the eight registers of the bank that is not in use. Control-register move instructions use it to load or save the shadowed copy. An exception-entry pulse puts the block in privileged mode with bank 1 selected, so a handler gets fresh low registers without saving anything. A status-update input lets the core load both state bits.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous reset clears all twenty-four registers to zero and sets privMode=1 and bankSel=1. After reset, altIllegal is 0.
- R2: Read or write indices 8 to 15 reach the same eight shared registers in every combination of privMode and bankSel.
- R3: With privMode=0, indices 0 to 7 reach bank 0 whatever the value of bankSel.
- R4: With privMode=1, indices 0 to 7 reach bank 1 when bankSel=1 and bank 0 when bankSel=0.
- R5: An excEntry pulse sets privMode=1 and bankSel=1 from the next cycle. It wins over a status write in the same cycle.
- R6: A status write (statWrEn=1 without excEntry) loads privMode from statPriv and bankSel from statBank, visible from the next cycle.
- R7: With privMode=1, the alternate port (altAddr 0 to 7) reads and, with altEn=1 and altWrite=1, writes the register of that index in the bank that is not selected. A normal write and an alternate write in the same cycle both take effect. If they ever named one physical register, the normal write would win.
- R8: With privMode=0, altRdData reads 0 and an alternate write is ignored. Any alternate access (altEn=1) drives altIllegal high for exactly the next cycle.
- R9: Reads are combinational and use the bank selection of the current cycle. A write lands at the rising edge in the bank selected in the cycle it is presented. A read of that register in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 4 | Architectural index for read port A |
| rdDataA | output | 32 | Read port A data, combinational |
| rdAddrB | input | 4 | Architectural index for read port B |
| rdDataB | output | 32 | Read port B data, combinational |
| wrEn | input | 1 | Normal write enable |
| wrAddr | input | 4 | Normal write architectural index |
| wrData | input | 32 | Normal write data |
| altEn | input | 1 | Alternate-bank access request |
| altWrite | input | 1 | Alternate access is a write when 1 |
| altAddr | input | 3 | Index inside the non-selected bank |
| altWrData | input | 32 | Alternate write data |
| altRdData | output | 32 | Alternate read data; 0 in user mode |
| excEntry | input | 1 | Exception-entry pulse |
| statWrEn | input | 1 | Load the mode and bank bits |
| statPriv | input | 1 | New privileged-mode bit |
| statBank | input | 1 | New bank-select bit |
| privMode | output | 1 | Current privileged-mode bit |
| bankSel | output | 1 | Current bank-select bit |
| altIllegal | output | 1 | One-cycle flag after a user-mode alternate access |

## Verification
Read data on all three read ports is due in the same cycle as its address, so the bench compares it a nanosecond after it drives inputs on the falling edge, before the next rising edge. Writes, mode and bank updates, and the altIllegal flag are due one rising edge later. The bench updates its reference model only after that edge. Each comparison made before the edge therefore sees the old contents, and the one after it sees the new state. Random traffic mixes mode changes, exception pulses and alternate accesses. Directed sequences force same-cycle read-during-write, exception entry colliding with a status write, and user-mode alternate attempts.

// File: rtl/brf_pkg.sv
package brf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic actBank;     // bank used for indices below the banked count
    logic altVisible;  // alternate port may be seen (privileged)
    logic altWr;       // qualified alternate write
  } brf_strobe_t;
endpackage

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        excEntry,
  input  logic        statWrEn,
  input  logic        statPriv,
  input  logic        statBank,
  input  logic        altEn,
  input  logic        altWrite,
  output logic        privMode,
  output logic        bankSel,
  output logic        altIllegal,
  output brf_strobe_t stb
);
  logic privNext, bankNext, illegalNext;

  always_comb begin
    privNext = privMode;
    bankNext = bankSel;
    if (excEntry) begin
      privNext = 1'b1;
      bankNext = 1'b1;
    end else if (statWrEn) begin
      privNext = statPriv;
      bankNext = statBank;
    end
    illegalNext = altEn && !privMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      privMode   <= 1'b1;
      bankSel    <= 1'b1;
      altIllegal <= 1'b0;
    end else begin
      privMode   <= privNext;
      bankSel    <= bankNext;
      altIllegal <= illegalNext;
    end
  end

  always_comb begin
    stb.actBank    = privMode && bankSel;
    stb.altVisible = privMode;
    stb.altWr      = privMode && altEn && altWrite;
  end

  // R5: exception entry forces privileged bank 1
  p_exc_entry_r5: assert property (@(posedge clk) disable iff (rst)
    excEntry |=> (privMode && bankSel));

  // R6: status write loads both bits
  p_stat_load_r6: assert property (@(posedge clk) disable iff (rst)
    (statWrEn && !excEntry) |=> (privMode == $past(statPriv) && bankSel == $past(statBank)));

  // R8: illegal flag follows a user-mode alternate access
  p_illegal_set_r8: assert property (@(posedge clk) disable iff (rst)
    (altEn && !privMode) |=> altIllegal);

  p_illegal_clr_r8: assert property (@(posedge clk) disable iff (rst)
    !(altEn && !privMode) |=> !altIllegal);

endmodule

// File: rtl/brf_datapath.sv
module brf_datapath
  import brf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_BANKED = 8,
  parameter int N_SHARED = 8,
  localparam int ARCH_N  = N_BANKED + N_SHARED,
  localparam int PHYS_N  = 2 * N_BANKED + N_SHARED,
  localparam int AW      = $clog2(ARCH_N),
  localparam int BW      = $clog2(N_BANKED),
  localparam int PW      = $clog2(PHYS_N)
)(
  input  logic              clk,
  input  logic              rst,
  input  brf_strobe_t       stb,
  input  logic [AW-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BW-1:0]     altAddr,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData
);
  // Physical layout: bank 0, bank 1, shared
  logic [DATA_W-1:0] regs [PHYS_N];
  logic [PW-1:0]     wrPhys, altPhys, rdPhysA, rdPhysB;

  function automatic logic [PW-1:0] physOf(input logic [AW-1:0] a, input logic bk);
    if (int'(a) < N_BANKED)
      return bk ? PW'(int'(a) + N_BANKED) : PW'(a);
    else
      return PW'(int'(a) + N_BANKED);
  endfunction

  always_comb begin
    wrPhys  = physOf(wrAddr, stb.actBank);
    rdPhysA = physOf(rdAddrA, stb.actBank);
    rdPhysB = physOf(rdAddrB, stb.actBank);
    altPhys = stb.actBank ? PW'(altAddr) : PW'(int'(altAddr) + N_BANKED);
  end

  for (genvar g = 0; g < PHYS_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wrEn && wrPhys == PW'(g))
        regs[g] <= wrData;                // normal write has priority
      else if (stb.altWr && altPhys == PW'(g))
        regs[g] <= altWrData;
    end
  end

  always_comb begin
    rdDataA   = regs[rdPhysA];
    rdDataB   = regs[rdPhysB];
    altRdData = stb.altVisible ? regs[altPhys] : '0;
  end

  // R9: a written value is seen next cycle through the read port (same bank view)
  p_write_visible_r9: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> ((rdAddrA == $past(wrAddr) &&
               (int'($past(wrAddr)) >= N_BANKED || stb.actBank == $past(stb.actBank)))
              -> rdDataA == $past(wrData)));

  // R7: alternate write reaches the bank opposite the normal view
  p_alt_write_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.altWr && !(wrEn && int'(wrAddr) < N_BANKED)) |=>
      ((stb.actBank == $past(stb.actBank) && stb.altVisible && altAddr == $past(altAddr))
       -> altRdData == $past(altWrData)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_BANKED = 8,
  parameter int N_SHARED = 8,
  localparam int AW      = $clog2(N_BANKED + N_SHARED),
  localparam int BW      = $clog2(N_BANKED)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altEn,
  input  logic              altWrite,
  input  logic [BW-1:0]     altAddr,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData,
  input  logic              excEntry,
  input  logic              statWrEn,
  input  logic              statPriv,
  input  logic              statBank,
  output logic              privMode,
  output logic              bankSel,
  output logic              altIllegal
);
  brf_strobe_t stb;

  brf_ctrl i_ctrl (
    .clk(clk), .rst(rst), .excEntry(excEntry), .statWrEn(statWrEn),
    .statPriv(statPriv), .statBank(statBank), .altEn(altEn), .altWrite(altWrite),
    .privMode(privMode), .bankSel(bankSel), .altIllegal(altIllegal), .stb(stb)
  );

  brf_datapath #(.DATA_W(DATA_W), .N_BANKED(N_BANKED), .N_SHARED(N_SHARED)) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altAddr(altAddr), .altWrData(altWrData), .altRdData(altRdData)
  );

  // R1: state bits come out of reset privileged with bank 1
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (privMode && bankSel && !altIllegal));

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic clk = 1'b0;
  logic rst;
  logic [3:0] rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, altWrData, altRdData;
  logic wrEn, altEn, altWrite, excEntry, statWrEn, statPriv, statBank;
  logic [2:0] altAddr;
  logic privMode, bankSel, altIllegal;

  int checks = 0;
  int failures = 0;

  // reference model
  logic [31:0] mdl [24];
  logic mPriv, mBank, mIll;

  always #2 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .altEn(altEn), .altWrite(altWrite), .altAddr(altAddr),
    .altWrData(altWrData), .altRdData(altRdData), .excEntry(excEntry),
    .statWrEn(statWrEn), .statPriv(statPriv), .statBank(statBank),
    .privMode(privMode), .bankSel(bankSel), .altIllegal(altIllegal)
  );

  // index 0..7 -> bank selected (R3 user: bank0, R4 priv: bankSel), 8..15 -> shared (R2)
  function automatic int mPhys(input logic [3:0] a);
    logic act = mPriv & mBank;
    if (a < 8) return act ? int'(a) + 8 : int'(a);
    return int'(a) + 8;
  endfunction

  function automatic logic [31:0] mAlt(input logic [2:0] a);
    logic act = mPriv & mBank;
    if (!mPriv) return 32'h0;               // R8 user-mode read is zero
    return act ? mdl[int'(a)] : mdl[int'(a) + 8];  // R7 opposite bank
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check reads before the edge, update model after
  task automatic step(input logic [3:0] ra, input logic [3:0] rb,
                      input logic we, input logic [3:0] wa, input logic [31:0] wd,
                      input logic ae, input logic aw, input logic [2:0] aa, input logic [31:0] ad,
                      input logic ex, input logic sw, input logic sp, input logic sb);
    logic act;
    @(negedge clk);
    rdAddrA = ra; rdAddrB = rb; wrEn = we; wrAddr = wa; wrData = wd;
    altEn = ae; altWrite = aw; altAddr = aa; altWrData = ad;
    excEntry = ex; statWrEn = sw; statPriv = sp; statBank = sb;
    #1;
    chk("R9 rdDataA (R2/R3/R4 mapping)", rdDataA, mdl[mPhys(ra)]);
    chk("R9 rdDataB (R2/R3/R4 mapping)", rdDataB, mdl[mPhys(rb)]);
    chk("R7 altRdData", altRdData, mAlt(aa));
    chk("R5/R6 privMode", {31'h0, privMode}, {31'h0, mPriv});
    chk("R5/R6 bankSel", {31'h0, bankSel}, {31'h0, mBank});
    chk("R8 altIllegal", {31'h0, altIllegal}, {31'h0, mIll});
    @(posedge clk);
    act = mPriv & mBank;
    if (mPriv && ae && aw) mdl[act ? int'(aa) : int'(aa) + 8] = ad;  // R7
    if (we) mdl[mPhys(wa)] = wd;                                      // R9 old bank view
    mIll = ae & !mPriv;                                               // R8
    if (ex) begin mPriv = 1'b1; mBank = 1'b1; end                     // R5
    else if (sw) begin mPriv = sp; mBank = sb; end                    // R6
  endtask

  task automatic setStat(input logic p, input logic b);
    step(0, 8, 0, 0, 0, 0, 0, 0, 0, 0, 1, p, b);
  endtask

  initial begin
    #(4ns * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst = 1'b1;
    {wrEn, altEn, altWrite, excEntry, statWrEn, statPriv, statBank} = '0;
    rdAddrA = 0; rdAddrB = 0; wrAddr = 0; wrData = 0; altAddr = 0; altWrData = 0;
    for (int i = 0; i < 24; i++) mdl[i] = 32'h0;
    mPriv = 1'b1; mBank = 1'b1; mIll = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 privMode", {31'h0, privMode}, 32'h1);
    chk("R1 bankSel", {31'h0, bankSel}, 32'h1);
    chk("R1 altIllegal", {31'h0, altIllegal}, 32'h0);
    chk("R1 register zero", rdDataA, 32'h0);

    // R4: privileged bank 1 write R0, then bank 0 view
    step(0, 0, 1, 0, 32'hAAAA0001, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);      // priv, bank 0
    step(0, 0, 1, 0, 32'hBBBB0002, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R4 bank0 R0", rdDataA, 32'hBBBB0002);
    altAddr = 0; altEn = 0; #1;
    chk("R7 alt sees bank1 R0", altRdData, 32'hAAAA0001);
    // R9 read-during-write returns old value
    step(0, 0, 1, 0, 32'hCCCC0003, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 user mode with bankSel=1 still bank 0
    setStat(0, 1);
    step(0, 9, 1, 9, 32'h12345678, 1, 1, 0, 32'hDEAD0000, 0, 0, 0, 0); // R8 ignored write
    @(negedge clk); #1;
    chk("R3 user R0 is bank0", rdDataA, 32'hCCCC0003);
    chk("R8 altIllegal pulse", {31'h0, altIllegal}, 32'h1);
    chk("R8 user alt read zero", altRdData, 32'h0);
    // R5 exception wins over status write
    step(0, 9, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    @(negedge clk); #1;
    chk("R5 exc priv", {31'h0, privMode}, 32'h1);
    chk("R5 exc bank", {31'h0, bankSel}, 32'h1);
    chk("R8 bank1 R0 untouched", rdDataA, 32'hAAAA0001);
    chk("R2 shared R9", rdDataB, 32'h12345678);
    // R7 simultaneous normal and alternate write
    step(1, 2, 1, 1, 32'h11110001, 1, 1, 1, 32'h22220001, 0, 0, 0, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      step(4'($urandom), 4'($urandom), r[0], 4'($urandom), $urandom,
           (r[3:1] < 3), r[4], 3'($urandom), $urandom,
           (r[9:5] == 0), (r[13:10] < 2), r[14], r[15]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule